// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Interface

This block is the host-facing port of a small peripheral register file. A processor reaches it over eight shared address/data lines. Each bus cycle has two parts. First an address phase places a register address on the lines. Then a data phase uses the same lines to carry a byte in either direction. A static mode input chooses which of two strobe conventions the host uses.

With the mode input high, the host uses a data strobe plus a single read/write line. With it low, the host uses separate active-low read and write strobes. In both conventions an address strobe demultiplexes the lines. The falling edge of the address strobe captures the address whether or not chip select is asserted. Chip select qualifies only the data phase.

All bus inputs are treated as asynchronous. They pass through a synchronizer of `SYNC_STAGES` flops (default 2) before any edge is detected. The register file holds 64 bytes. Only the low six bits of the captured address select a byte. The pad-level tri-state buffer sits outside the block: the block supplies the outgoing byte and an output enable.

Top module: `mbus_host_if`

## Requirements
- R1: After reset the output enable is low, the outgoing byte is 0x00, and every one of the 64 registers reads back 0x00.
- R2: A falling edge of the address strobe captures the bus byte as the current address, whether chip select is high or low. The address is held until the next falling edge.
- R3: With `mode_sel`=1, a falling edge of `ds_rd_n` while `rw_wr_n`=0 and `cs_n`=0 writes the bus byte into the register at the current address.
- R4: With `mode_sel`=1, the output enable is high exactly while `ds_rd_n`=1, `rw_wr_n`=1 and `cs_n`=0, as seen after the synchronizer.
- R5: With `mode_sel`=0, a rising edge of `rw_wr_n` (the active-low write strobe) while `cs_n`=0 writes the bus byte into the register at the current address.
- R6: With `mode_sel`=0, the output enable is high exactly while `ds_rd_n` (the active-low read strobe) is 0 and `cs_n`=0.
- R7: While `cs_n`=1, no write takes effect and the output enable stays low.
- R8: While the output enable is high, `ad_out` carries the register at the current address. Otherwise `ad_out` is 0x00.
- R9: Address bits 7:6 are ignored. Addresses that differ only in those bits select the same register.
- R10: The byte stored by a write is the value on the bus at the committing strobe edge, not an earlier value from the same data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 1: data strobe + read/write line; 0: separate read and write strobes. Static |
| cs_n | input | 1 | Active-low chip select, qualifies data transfers |
| as_in | input | 1 | Address strobe; its falling edge captures the address |
| ds_rd_n | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_wr_n | input | 1 | Read/write line, 1 = read (mode 1), or active-low write strobe (mode 0) |
| ad_in | input | 8 | Multiplexed address/data lines as seen from the pad |
| ad_out | output | 8 | Byte driven toward the pad during reads |
| ad_oe | output | 1 | Output enable for the pad tri-state buffer |

## Verification
The hardest case to reach is a data transfer that uses an address captured while chip select was high. It is hard because a correct design shows no trace of that capture at the outputs until a later, selected data phase. The stimulus strobes an address with chip select deasserted. Only after that does it lower chip select for a read without a new address strobe, so the returned byte shows which address was held. Suppressed writes get the same treatment. A write attempted under a deasserted chip select is followed by a selected read of the same location, which must return the earlier contents. The per-cycle reference model follows every strobe edge through the synchronizer delay, so an edge detected one cycle early or late also shows up as a mismatch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int DATA_W = 8;

  // one synchronized sample of every bus input
  typedef struct packed {
    logic              mode;
    logic              cs_n;
    logic              as;
    logic              stb_a;   // data strobe or read strobe (active low)
    logic              stb_b;   // read/write line or write strobe (active low)
    logic [DATA_W-1:0] ad;
  } bus_smp_t;

  // strobes parked high so no edge is seen as reset is left
  localparam bus_smp_t SMP_IDLE = '{mode: 1'b1, cs_n: 1'b1, as: 1'b1,
                                    stb_a: 1'b1, stb_b: 1'b1, ad: '0};
endpackage

// File: rtl/mbus_rst_sync.sv
module mbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic r1_q, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_sn = r2_q;
endmodule

// File: rtl/mbus_sync_pipe.sv
module mbus_sync_pipe #(
  parameter int             W       = 13,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic [W-1:0] nxt;
    if (gi == 0) begin : g_first
      assign nxt = d;
    end else begin : g_chain
      assign nxt = stg[gi-1];
    end
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) stg[gi] <= RST_VAL;
      else         stg[gi] <= nxt;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec
  import mbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_sn,
  input  bus_smp_t smp,
  output logic     as_fall,
  output logic     wr_en,
  output logic     rd_en
);
  logic prv_as_q, prv_a_q, prv_b_q;
  logic wr_mot, wr_int, rd_mot, rd_int;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prv_as_q <= SMP_IDLE.as;
      prv_a_q  <= SMP_IDLE.stb_a;
      prv_b_q  <= SMP_IDLE.stb_b;
    end else begin
      prv_as_q <= smp.as;
      prv_a_q  <= smp.stb_a;
      prv_b_q  <= smp.stb_b;
    end
  end

  always_comb begin
    as_fall = prv_as_q & ~smp.as;
    // data strobe falls with the line in write direction
    wr_mot  = prv_a_q & ~smp.stb_a & ~smp.stb_b;
    // write strobe returns high
    wr_int  = ~prv_b_q & smp.stb_b;
    rd_mot  = smp.stb_a & smp.stb_b;
    rd_int  = ~smp.stb_a;
    wr_en   = ~smp.cs_n & (smp.mode ? wr_mot : wr_int);
    rd_en   = ~smp.cs_n & (smp.mode ? rd_mot : rd_int);
  end
endmodule

// File: rtl/mbus_reg_array.sv
module mbus_reg_array #(
  parameter int NREG = 64,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_byte
    logic hit;
    assign hit = wr_en && (addr == AW'(gi));
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)  mem_q[gi] <= '0;
      else if (hit) mem_q[gi] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/mbus_host_if.sv
module mbus_host_if
  import mbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NREG        = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              cs_n,
  input  logic              as_in,
  input  logic              ds_rd_n,
  input  logic              rw_wr_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  localparam int AW    = $clog2(NREG);
  localparam int SMP_W = $bits(bus_smp_t);

  logic              rst_sn;
  bus_smp_t          raw, smp_s;
  logic              as_fall, wr_en, rd_en;
  logic [AW-1:0]     addr_q, addr_nxt;
  logic [DATA_W-1:0] rdata;

  mbus_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign raw = '{mode: mode_sel, cs_n: cs_n, as: as_in,
                 stb_a: ds_rd_n, stb_b: rw_wr_n, ad: ad_in};

  mbus_sync_pipe #(.W(SMP_W), .STAGES(SYNC_STAGES), .RST_VAL(SMP_IDLE)) u_sync (
    .clk(clk), .rst_sn(rst_sn), .d(raw), .q(smp_s)
  );

  mbus_strobe_dec u_dec (
    .clk(clk), .rst_sn(rst_sn), .smp(smp_s),
    .as_fall(as_fall), .wr_en(wr_en), .rd_en(rd_en)
  );

  // address latch: independent of chip select
  always_comb begin
    addr_nxt = addr_q;
    if (as_fall) addr_nxt = smp_s.ad[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) addr_q <= '0;
    else         addr_q <= addr_nxt;
  end

  mbus_reg_array #(.NREG(NREG), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en),
    .addr(addr_q), .wdata(smp_s.ad), .rdata(rdata)
  );

  assign ad_oe  = rd_en;
  assign ad_out = rd_en ? rdata : '0;
endmodule

// File: rtl/mbus_host_if_chk.sv
module mbus_host_if_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          s_mode,
  input logic          s_cs_n,
  input logic          s_stb_a,
  input logic          s_stb_b,
  input logic [AW-1:0] s_ad_lo,
  input logic          as_fall,
  input logic          wr_en,
  input logic [AW-1:0] addr_q,
  input logic          ad_oe,
  input logic [7:0]    ad_out
);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !as_fall |=> $stable(addr_q));

  assert_addr_take_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    as_fall |=> addr_q == $past(s_ad_lo));

  assert_write_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en |-> !s_cs_n);

  assert_oe_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    ad_oe |-> !s_cs_n);

  assert_mot_read_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (s_mode && s_stb_a && s_stb_b && !s_cs_n) |-> ad_oe);

  assert_int_read_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!s_mode && !s_stb_a && !s_cs_n) |-> ad_oe);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !ad_oe |-> ad_out == 8'h00);
endmodule

bind mbus_host_if mbus_host_if_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .s_mode(smp_s.mode), .s_cs_n(smp_s.cs_n),
  .s_stb_a(smp_s.stb_a), .s_stb_b(smp_s.stb_b), .s_ad_lo(smp_s.ad[AW-1:0]),
  .as_fall(as_fall), .wr_en(wr_en), .addr_q(addr_q),
  .ad_oe(ad_oe), .ad_out(ad_out)
);

// File: tb/sim_mbus_host_if.sv
module sim_mbus_host_if;
  import mbus_pkg::*;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b1, cs_n = 1'b1, as_in = 1'b0, stb_a = 1'b0, stb_b = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic       ad_oe;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] sb [64];

  always #4 clk = ~clk;

  mbus_host_if #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .as_in(as_in),
    .ds_rd_n(stb_a), .rw_wr_n(stb_b), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  // ---------------- behavioural reference model ----------------
  bus_smp_t   mq[$];
  bus_smp_t   cur, prv;
  logic [7:0] mmem [64];
  int         maddr, hold;

  function automatic bit m_read();
    if (cur.cs_n) return 0;
    return cur.mode ? (cur.stb_a && cur.stb_b) : !cur.stb_a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < SYNC - 1; i++) mq.push_back(SMP_IDLE);
      cur = SMP_IDLE; prv = SMP_IDLE; maddr = 0; hold = 2;
      for (int i = 0; i < 64; i++) mmem[i] = 8'h00;
    end else if (hold > 0) begin
      hold--;
    end else begin
      if (!cur.cs_n) begin
        if (cur.mode && prv.stb_a && !cur.stb_a && !cur.stb_b) mmem[maddr] = cur.ad;
        if (!cur.mode && !prv.stb_b && cur.stb_b)              mmem[maddr] = cur.ad;
      end
      if (prv.as && !cur.as) maddr = cur.ad % 64;
      prv = cur;
      mq.push_back('{mode_sel, cs_n, as_in, stb_a, stb_b, ad_in});
      cur = mq.pop_front();
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (ad_oe !== m_read()) begin
        bad++;
        $display("FAIL R4/R6 cycle oe act=%0b exp=%0b", ad_oe, m_read());
      end
      total++;
      if (ad_out !== (m_read() ? mmem[maddr] : 8'h00)) begin
        bad++;
        $display("FAIL R8 cycle data act=%h exp=%h", ad_out,
                 m_read() ? mmem[maddr] : 8'h00);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; mode_sel = mode; cs_n = 1'b1; as_in = 1'b0; ad_in = 8'h00;
    stb_a = mode ? 1'b0 : 1'b1; stb_b = 1'b1;
    for (int i = 0; i < 64; i++) sb[i] = 8'h00;
    step(3); rst_n = 1'b1; step(6);
  endtask

  task automatic latch(input logic [7:0] a, input logic sel_n);
    ad_in = a; cs_n = sel_n; as_in = 1'b1; step(4);
    as_in = 1'b0; step(4); cs_n = 1'b1;
  endtask

  task automatic mot_wr(input logic [7:0] a, input logic [7:0] d, input logic sel_n);
    latch(a, 1'b1);
    cs_n = sel_n; stb_b = 1'b0; ad_in = d; stb_a = 1'b1; step(4);
    stb_a = 1'b0; step(4); stb_b = 1'b1; cs_n = 1'b1; step(2);
    if (!sel_n) sb[a % 64] = d;
  endtask

  task automatic mot_rd(input logic [7:0] a, input logic sel_n, input string req);
    latch(a, 1'b1);
    cs_n = sel_n; stb_b = 1'b1; ad_in = 8'h5A; stb_a = 1'b1; step(4);
    chk(ad_oe == !sel_n, req, {7'd0, ad_oe}, {7'd0, !sel_n});
    chk(ad_out == (sel_n ? 8'h00 : sb[a % 64]), req, ad_out, sel_n ? 8'h00 : sb[a % 64]);
    stb_a = 1'b0; cs_n = 1'b1; step(2);
  endtask

  task automatic int_wr(input logic [7:0] a, input logic [7:0] d, input logic sel_n);
    latch(a, 1'b1);
    cs_n = sel_n; ad_in = d; stb_b = 1'b0; step(4);
    stb_b = 1'b1; step(4); cs_n = 1'b1; step(2);
    if (!sel_n) sb[a % 64] = d;
  endtask

  task automatic int_rd(input logic [7:0] a, input logic sel_n, input string req);
    latch(a, 1'b1);
    cs_n = sel_n; ad_in = 8'hA5; stb_a = 1'b0; step(4);
    chk(ad_oe == !sel_n, req, {7'd0, ad_oe}, {7'd0, !sel_n});
    chk(ad_out == (sel_n ? 8'h00 : sb[a % 64]), req, ad_out, sel_n ? 8'h00 : sb[a % 64]);
    stb_a = 1'b1; cs_n = 1'b1; step(2);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    do_reset(1'b1);
    // R1: reset state
    chk(ad_oe == 1'b0, "R1 oe after reset", {7'd0, ad_oe}, 8'h00);
    chk(ad_out == 8'h00, "R1 out after reset", ad_out, 8'h00);
    mot_rd(8'd0, 1'b0, "R1 reg0 reset");
    mot_rd(8'd63, 1'b0, "R1 reg63 reset");

    // R3/R4: data strobe + read/write line
    mot_wr(8'd3, 8'hA5, 1'b0);
    mot_rd(8'd3, 1'b0, "R3 R4 reg3");
    mot_wr(8'd63, 8'h3C, 1'b0);
    mot_rd(8'd63, 1'b0, "R3 R4 reg63");
    // R9: bits 7:6 ignored
    mot_rd(8'hC3, 1'b0, "R9 alias C3->3");
    mot_wr(8'h7F, 8'h42, 1'b0);
    mot_rd(8'd63, 1'b0, "R9 alias write 7F->63");
    // R7: deselected write ignored, deselected read not driven
    mot_wr(8'd3, 8'hFF, 1'b1);
    mot_rd(8'd3, 1'b0, "R7 write ignored");
    mot_rd(8'd3, 1'b1, "R7 read not driven");

    // R10: value at the commit edge is stored
    latch(8'd10, 1'b1);
    cs_n = 1'b0; stb_b = 1'b0; ad_in = 8'h11; stb_a = 1'b1; step(4);
    ad_in = 8'h77; step(4);
    stb_a = 1'b0; step(4); stb_b = 1'b1; cs_n = 1'b1; step(2);
    sb[10] = 8'h77;
    mot_rd(8'd10, 1'b0, "R10 last bus value");

    // R2: address captured with chip select high, used by a later selected read
    latch(8'd63, 1'b1);
    latch(8'd10, 1'b1);
    cs_n = 1'b0; stb_b = 1'b1; stb_a = 1'b1; step(4);
    chk(ad_out == sb[10], "R2 latch without cs", ad_out, sb[10]);
    stb_a = 1'b0; cs_n = 1'b1; step(2);

    // separate read and write strobes
    do_reset(1'b0);
    int_rd(8'd5, 1'b0, "R1 reg5 after mode reset");
    int_wr(8'd5, 8'h81, 1'b0);
    int_rd(8'd5, 1'b0, "R5 R6 reg5");
    int_wr(8'd40, 8'hC7, 1'b0);
    int_rd(8'd40, 1'b0, "R5 R6 reg40");
    int_wr(8'd5, 8'h11, 1'b1);
    int_rd(8'd5, 1'b0, "R7 strobe write ignored");
    int_rd(8'd5, 1'b1, "R7 strobe read not driven");
    int_rd(8'h45, 1'b0, "R9 alias 45->5");
    // R6: read strobe released, still selected -> not driven
    cs_n = 1'b0; stb_a = 1'b1; step(4);
    chk(ad_oe == 1'b0, "R6 idle read strobe", {7'd0, ad_oe}, 8'h00);
    cs_n = 1'b1; step(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule